// File: doc/BRIEF.md
# Serial Dongle Management Master

This block drives the two-wire management link of an infrared transceiver dongle in hardware, so software no longer toggles the clock and data pins by hand. The host presents an operation (write, read or reset), a 7-bit device address, a register index and a write byte, then pulses `start`. The engine produces every clock edge and bit time itself, samples the dongle's combined valid/data return line, and reports completion with a one-cycle `done` pulse. Reads also return a byte and a flag that shows whether the dongle answered.

Each clock pulse is a low period of two time units followed by a high period of one unit. The unit is `half_period` system cycles, and a value of zero counts as one. TX only changes while the clock is low. The link has no acknowledge bit. Instead, a read polls a bounded number of pulses for the return line to go low, and every operation ends with a fixed number of trailer pulses.

Top module: `dgl_mgmt_master`

## Requirements
- R1: The command byte equals `{1'b0,dev_addr} | (reg_idx << 1) | dir`, where dir (bit 0) is 1 for a write and 0 for a read. `op` encoding: 0 = write, 1 = read, 2 or 3 = reset.
- R2: Every byte goes out least significant bit first. Each pulse holds the clock low for 2U cycles and high for U cycles, where U = max(half_period,1), and TX never changes while the clock is high.
- R3: A write or a read begins with one start-marker pulse that has TX high.
- R4: A write sends the marker, the command byte and the data byte, then two trailer pulses with TX low: 19 pulses in total.
- R5: After the read command byte, TX is low and up to 10 poll pulses follow. `dgl_in` is sampled in the cycle that ends each pulse's high time, and the first low sample ends the poll.
- R6: When the poll succeeds, the next 8 pulses capture a byte LSB first from `dgl_in` into `rd_data`, and `rd_timeout` stays 0.
- R7: When all 10 poll samples are high, only 2 dummy pulses follow, `rd_data` is 0 and `rd_timeout` is 1.
- R8: Every read ends with 4 trailer pulses with TX low. A read therefore has 22+k pulses when valid is seen on poll pulse k (0-based), and 25 pulses when it times out.
- R9: A reset operation sends 30 pulses with TX low and no start marker.
- R10: `busy` rises in the cycle after `start` is accepted. `done` is high for exactly one cycle, at which point `busy`, `sclk` and `stx` are low. From acceptance to `done` the operation takes 3·U·P cycles for P pulses.
- R11: A `start` that arrives while `busy` is high is ignored. The running operation is unchanged and no second operation follows.
- R12: After reset, `sclk`, `stx`, `busy`, `done`, `rd_data` and `rd_timeout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | PRE_W | Time unit U in cycles (0 acts as 1) |
| start | input | 1 | Operation request strobe |
| op | input | 2 | 0 write, 1 read, 2/3 reset |
| dev_addr | input | 7 | Device address folded into the command byte |
| reg_idx | input | IDX_W | Register index |
| wr_data | input | 8 | Byte to write |
| dgl_in | input | 1 | Dongle return line (valid when low, then data) |
| sclk | output | 1 | Serial clock to the dongle |
| stx | output | 1 | Serial data to the dongle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read (0 otherwise) |
| rd_timeout | output | 1 | Last read saw no valid response |

## Verification
The bench focuses on the edges of the poll window. A dongle that answers on the first poll pulse, one that answers on the tenth, and one that never answers all appear. A design with an off-by-one poll limit shows up as a wrong pulse count or a spurious timeout. If the data shift runs in the wrong direction, the read-back bytes come out reversed. If the idle or marker level of TX is wrong, the recorded TX bit sequence no longer matches the computed one. A start pulse injected mid-operation catches a design that restarts or queues a second operation, and duration checks at several prescaler values catch a design whose low and high times are miscounted.

// File: rtl/dgl_pkg.sv
package dgl_pkg;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;

    typedef enum logic [3:0] {
        SEG_IDLE  = 4'd0,
        SEG_START = 4'd1,
        SEG_CMD   = 4'd2,
        SEG_WDAT  = 4'd3,
        SEG_WTAIL = 4'd4,
        SEG_POLL  = 4'd5,
        SEG_RDAT  = 4'd6,
        SEG_DUMMY = 4'd7,
        SEG_RTAIL = 4'd8,
        SEG_RST   = 4'd9
    } seg_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW0 = 2'd1,
        PH_LOW1 = 2'd2,
        PH_HIGH = 2'd3
    } ph_e;

endpackage

// File: rtl/dgl_tick.sv
module dgl_tick #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] half_period,
    output logic             tick
);
    logic [PRE_W-1:0] lim_m1;
    logic [PRE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        lim_m1 = (half_period == '0) ? '0 : half_period - 1'b1;
        tick   = en && (cnt_q == lim_m1);
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dgl_pulse.sv
module dgl_pulse
    import dgl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic stop,
    input  logic tick,
    output logic sclk,
    output logic fall,
    output logic active
);
    ph_e ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE: if (launch) ph_d = PH_LOW0;
            PH_LOW0: if (tick)   ph_d = PH_LOW1;
            PH_LOW1: if (tick)   ph_d = PH_HIGH;
            PH_HIGH: if (tick)   ph_d = stop ? PH_IDLE : PH_LOW0;
            default: ph_d = PH_IDLE;
        endcase
    end

    assign sclk   = (ph_q == PH_HIGH);
    assign fall   = (ph_q == PH_HIGH) && tick;
    assign active = (ph_q != PH_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/dgl_mgmt_master.sv
module dgl_mgmt_master
    import dgl_pkg::*;
#(
    parameter int PRE_W        = 8,
    parameter int IDX_W        = 3,
    parameter int POLL_MAX     = 10,
    parameter int DUMMY_PULSES = 2,
    parameter int WR_TRAIL     = 2,
    parameter int RD_TRAIL     = 4,
    parameter int RST_PULSES   = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] half_period,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [6:0]       dev_addr,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [7:0]       wr_data,
    input  logic             dgl_in,
    output logic             sclk,
    output logic             stx,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rd_data,
    output logic             rd_timeout
);
    localparam int MAX_A   = (RST_PULSES > POLL_MAX) ? RST_PULSES : POLL_MAX;
    localparam int MAX_CNT = (MAX_A > 8) ? MAX_A : 8;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(7);
    localparam logic [CNT_W-1:0] LAST_POLL  = CNT_W'(POLL_MAX - 1);
    localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_PULSES - 1);
    localparam logic [CNT_W-1:0] LAST_WTAIL = CNT_W'(WR_TRAIL - 1);
    localparam logic [CNT_W-1:0] LAST_RTAIL = CNT_W'(RD_TRAIL - 1);
    localparam logic [CNT_W-1:0] LAST_RST   = CNT_W'(RST_PULSES - 1);

    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
        logic             is_wr;
        logic [7:0]       cmd;
        logic [7:0]       wdat;
        logic [7:0]       rdat;
        logic             tmo;
        logic             tx;
        logic             busy;
        logic             done;
    } st_t;

    st_t  st_d, st_q;
    logic launch, finish, fall, tick, active;
    logic [7:0] cmd_byte;

    dgl_tick #(.PRE_W(PRE_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .en(active),
        .half_period(half_period), .tick(tick)
    );

    dgl_pulse pulse_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .stop(finish),
        .tick(tick), .sclk(sclk), .fall(fall), .active(active)
    );

    always_comb begin
        cmd_byte = {1'b0, dev_addr} | (8'(reg_idx) << 1) | {7'b0, op == OP_WR};
        st_d      = st_q;
        st_d.done = 1'b0;
        launch    = 1'b0;
        finish    = 1'b0;
        if (st_q.seg == SEG_IDLE) begin
            if (start) begin
                launch     = 1'b1;
                st_d.busy  = 1'b1;
                st_d.cnt   = '0;
                st_d.rdat  = '0;
                st_d.tmo   = 1'b0;
                st_d.is_wr = (op == OP_WR);
                st_d.cmd   = cmd_byte;
                st_d.wdat  = wr_data;
                if (op == OP_WR || op == OP_RD) begin
                    st_d.seg = SEG_START;
                    st_d.tx  = 1'b1;
                end else begin
                    st_d.seg = SEG_RST;
                    st_d.tx  = 1'b0;
                end
            end
        end else if (fall) begin
            st_d.cnt = st_q.cnt + 1'b1;
            case (st_q.seg)
                SEG_START: begin
                    st_d.seg = SEG_CMD;
                    st_d.cnt = '0;
                    st_d.tx  = st_q.cmd[0];
                end
                SEG_CMD: begin
                    st_d.cmd = st_q.cmd >> 1;
                    st_d.tx  = st_q.cmd[1];
                    if (st_q.cnt == LAST_BIT) begin
                        st_d.cnt = '0;
                        if (st_q.is_wr) begin
                            st_d.seg = SEG_WDAT;
                            st_d.tx  = st_q.wdat[0];
                        end else begin
                            st_d.seg = SEG_POLL;
                            st_d.tx  = 1'b0;
                        end
                    end
                end
                SEG_WDAT: begin
                    st_d.wdat = st_q.wdat >> 1;
                    st_d.tx   = st_q.wdat[1];
                    if (st_q.cnt == LAST_BIT) begin
                        st_d.seg = SEG_WTAIL;
                        st_d.cnt = '0;
                        st_d.tx  = 1'b0;
                    end
                end
                SEG_WTAIL: if (st_q.cnt == LAST_WTAIL) finish = 1'b1;
                SEG_POLL: begin
                    if (!dgl_in) begin
                        st_d.seg = SEG_RDAT;
                        st_d.cnt = '0;
                    end else if (st_q.cnt == LAST_POLL) begin
                        st_d.seg = SEG_DUMMY;
                        st_d.cnt = '0;
                    end
                end
                SEG_RDAT: begin
                    st_d.rdat = {dgl_in, st_q.rdat[7:1]};
                    if (st_q.cnt == LAST_BIT) begin
                        st_d.seg = SEG_RTAIL;
                        st_d.cnt = '0;
                    end
                end
                SEG_DUMMY: begin
                    if (st_q.cnt == LAST_DUMMY) begin
                        st_d.seg  = SEG_RTAIL;
                        st_d.cnt  = '0;
                        st_d.tmo  = 1'b1;
                        st_d.rdat = '0;
                    end
                end
                SEG_RTAIL: if (st_q.cnt == LAST_RTAIL) finish = 1'b1;
                SEG_RST:   if (st_q.cnt == LAST_RST)   finish = 1'b1;
                default:   finish = 1'b1;
            endcase
            if (finish) begin
                st_d.seg  = SEG_IDLE;
                st_d.cnt  = '0;
                st_d.tx   = 1'b0;
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stx        = st_q.tx;
    assign busy       = st_q.busy;
    assign done       = st_q.done;
    assign rd_data    = st_q.rdat;
    assign rd_timeout = st_q.tmo;
endmodule

// File: rtl/dgl_mgmt_master_chk.sv
module dgl_mgmt_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       sclk,
    input logic       stx,
    input logic [7:0] rd_data,
    input logic       rd_timeout
);
    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_lines_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sclk && !stx && !busy));

    a_r10_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r2_tx_steady_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(stx));

    a_r12_clock_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    a_r7_timeout_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_timeout) |-> (rd_data == 8'h00));
endmodule

bind dgl_mgmt_master dgl_mgmt_master_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .sclk(sclk), .stx(stx), .rd_data(rd_data), .rd_timeout(rd_timeout)
);

// File: tb/dgl_mgmt_master_tb_top.sv
`timescale 1ns/1ps
module dgl_mgmt_master_tb_top;
    localparam int PRE_W = 8;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PRE_W-1:0] half_period = '0;
    logic start = 1'b0;
    logic [1:0] op = 2'd0;
    logic [6:0] dev_addr = '0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic [7:0] wr_data = '0;
    logic dgl_in;
    logic sclk, stx, busy, done, rd_timeout;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dgl_mgmt_master dut_i (
        .clk(clk), .rst_n(rst_n), .half_period(half_period), .start(start),
        .op(op), .dev_addr(dev_addr), .reg_idx(reg_idx), .wr_data(wr_data),
        .dgl_in(dgl_in), .sclk(sclk), .stx(stx), .busy(busy), .done(done),
        .rd_data(rd_data), .rd_timeout(rd_timeout)
    );

    // behavioural dongle model
    logic       mdl_out = 1'b1;
    int         pc = 0;
    int         lat_cfg = 0;
    logic [7:0] mcmd = '0;
    logic [7:0] mdat = '0;
    logic [7:0] mreg [8];
    logic       rec [64];
    logic [7:0] exp_reg [8];
    assign dgl_in = mdl_out;

    initial begin
        for (int i = 0; i < 8; i++) begin
            mreg[i]    = 8'(i * 37 + 5);
            exp_reg[i] = 8'(i * 37 + 5);
        end
    end

    always @(posedge sclk) begin
        if (pc < 64) rec[pc] = stx;
        if (pc >= 1 && pc <= 8) mcmd[pc-1] = stx;
        if (pc >= 9 && mcmd[0]) begin
            if (pc <= 16) mdat[pc-9] = stx;
            if (pc == 16) mreg[mcmd[3:1]] = mdat;
        end else if (pc >= 9) begin
            if (lat_cfg < 10 && pc == 9 + lat_cfg) mdl_out = 1'b0;
            else if (lat_cfg < 10 && pc >= 10 + lat_cfg && pc < 18 + lat_cfg)
                mdl_out = mreg[mcmd[3:1]][pc-10-lat_cfg];
            else mdl_out = 1'b1;
        end
        pc = pc + 1;
    end

    task automatic check(input string req, input logic ok, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] mk_cmd(input logic [1:0] o, input logic [6:0] a,
                                          input logic [IDX_W-1:0] ix);
        return {1'b0, a} | (8'(ix) << 1) | {7'b0, o == 2'd0};
    endfunction

    function automatic int exp_pulses(input logic [1:0] o, input int lat);
        if (o == 2'd0) return 19;
        if (o == 2'd1) return (lat < 10) ? 22 + lat : 25;
        return 30;
    endfunction

    function automatic logic exp_bit(input logic [1:0] o, input logic [7:0] c,
                                     input logic [7:0] wd, input int p);
        if (o >= 2'd2) return 1'b0;
        if (p == 0) return 1'b1;
        if (p <= 8) return c[p-1];
        if (o == 2'd0 && p <= 16) return wd[p-9];
        return 1'b0;
    endfunction

    task automatic run_op(input logic [1:0] o, input logic [6:0] a,
                          input logic [IDX_W-1:0] ix, input logic [7:0] wd,
                          input int lat, input int hp, input bit inject);
        int n = 0;
        int u = (hp == 0) ? 1 : hp;
        int p_exp = exp_pulses(o, lat);
        logic [7:0] c = mk_cmd(o, a, ix);
        int bad = -1;
        @(negedge clk);
        pc = 0; lat_cfg = lat; mdl_out = 1'b1; mcmd = '0;
        half_period = PRE_W'(hp); op = o; dev_addr = a; reg_idx = ix; wr_data = wd;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", busy === 1'b1, busy, 1);
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (inject && n == 5) begin
                start = 1'b1; op = 2'd2; reg_idx = ~ix; wr_data = ~wd;
            end else start = 1'b0;
            if (done) break;
            if (n > 20000) break;
        end
        check("R10 duration", n == 3 * u * p_exp, n, 3 * u * p_exp);
        check("R10 lines idle at done", !sclk && !stx && !busy, {sclk, stx, busy}, 0);
        check("R4/R8/R9 pulse count", pc == p_exp, pc, p_exp);
        for (int p = 0; p < p_exp && p < 64; p++)
            if (bad < 0 && rec[p] !== exp_bit(o, c, wd, p)) bad = p;
        check("R1/R2/R3 tx bit sequence", bad < 0, bad, -1);
        if (o == 2'd0) exp_reg[ix] = wd;
        if (o == 2'd1) begin
            if (lat < 10) begin
                check("R6 read data", rd_data == exp_reg[ix], rd_data, exp_reg[ix]);
                check("R6 no timeout", rd_timeout == 1'b0, rd_timeout, 0);
            end else begin
                check("R7 timeout data zero", rd_data == 8'h00, rd_data, 0);
                check("R7 timeout flag", rd_timeout == 1'b1, rd_timeout, 1);
            end
        end
        @(negedge clk);
        check("R10 done one cycle", done == 1'b0, done, 0);
        repeat (3) @(negedge clk);
        check("R11 no second operation", !busy && !done && !sclk, {busy, done, sclk}, 0);
    endtask

    initial begin
        #800000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int r;
        r = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check("R12 reset outputs", {sclk, stx, busy, done, rd_data, rd_timeout} == '0,
              {sclk, stx, busy, done, rd_data, rd_timeout}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corner cases
        run_op(2'd0, 7'h40, 3'd2, 8'h5A, 0, 0, 1'b0);   // R4 write
        run_op(2'd1, 7'h40, 3'd2, 8'h00, 0, 0, 1'b0);   // R5/R6 valid on first poll
        run_op(2'd1, 7'h40, 3'd5, 8'h00, 9, 2, 1'b0);   // R5 valid on last poll
        run_op(2'd1, 7'h40, 3'd1, 8'h00, 10, 1, 1'b0);  // R7 never valid
        run_op(2'd2, 7'h00, 3'd0, 8'h00, 12, 0, 1'b0);  // R9 reset
        run_op(2'd3, 7'h10, 3'd7, 8'hFF, 12, 3, 1'b0);  // R1 op 3 acts as reset
        run_op(2'd0, 7'h30, 3'd6, 8'hC3, 0, 1, 1'b1);   // R11 start while busy
        run_op(2'd1, 7'h30, 3'd6, 8'h00, 3, 4, 1'b1);   // R11 during read
        // random mix
        for (int k = 0; k < 40; k++) begin
            logic [1:0] o = 2'($urandom % 4);
            logic [6:0] a = {3'($urandom % 8), 4'b0};
            logic [IDX_W-1:0] ix = IDX_W'($urandom % 8);
            logic [7:0] wd = 8'($urandom);
            int lat = $urandom % 13;
            int hp = $urandom % 4;
            run_op(o, a, ix, wd, lat, hp, ($urandom % 5) == 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule